// File: doc/BRIEF.md
# Sparse Delta Matrix-Vector Accumulator

This block keeps a running matrix-vector product up to date from a stream of changes to the input vector. Each timestep the producer sends (column index, delta) pairs, one per cycle, and then an end-of-timestep pulse. A pair with a nonzero delta causes one read of the matching weight column from an external weight memory. Every row's weight is multiplied by the delta, and the products are added into per-row accumulators that persist from one timestep to the next. A pair whose delta is zero causes no memory read and no arithmetic, so the cost of a timestep tracks the number of nonzero deltas and not the vector length.

At the start of a sequence the accumulators are seeded from a bias vector. A path that carries only the recurrent contribution can instead be seeded with zero. The rows are split evenly among a parameterizable number of MAC lanes, so a whole column is consumed in one cycle. A done pulse marks the point at which every pair sent at or before the end marker has been folded into the accumulators. The accumulators are visible as raw Q16.16 values and as rescaled Q8.8 results.

Top module: `delta_mxv_acc`

## Requirements
- R1: A pair can be accepted on every cycle with no stall. For a nonzero delta, `wmem_rd_en` is high in the same cycle and `wmem_rd_col` equals the pair's index. The column is expected on `wmem_rd_data` on the next cycle, with row r in bits [16r+15:16r].
- R2: Each accepted pair adds weight(index,row) × delta into every row accumulator, with both operands signed 16-bit Q8.8 and the product signed 32-bit Q16.16. The new sum is visible on `acc_vec` in the third cycle after the pair is presented.
- R3: A pair with delta equal to zero produces no weight-memory read and leaves every accumulator unchanged.
- R4: A one-cycle `bias_load` sets row r's accumulator, on the next cycle, to the signed 16-bit bias r shifted left by 8 when `bias_use` is 1, and to zero when `bias_use` is 0. The load takes priority over a pending addition.
- R5: `done` is high for one cycle, three cycles after the cycle in which `ts_end` is high. At that point `acc_vec` includes every pair presented at or before the `ts_end` cycle.
- R6: Each accumulator saturates at 0x7FFFFFFF and 0x80000000 and does not wrap around.
- R7: `res_vec` row r equals bits [15:0] of accumulator r arithmetically shifted right by 8 (Q8.8).
- R8: After reset, every accumulator is zero and `done` and `wmem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_load | input | 1 | Seed accumulators this cycle |
| bias_use | input | 1 | 1: seed from bias, 0: seed with zero |
| bias_vec | input | ROWS*16 | Per-row Q8.8 bias |
| in_valid | input | 1 | Pair present |
| in_idx | input | $clog2(COLS) | Column index of the pair |
| in_delta | input | 16 | Signed Q8.8 delta |
| ts_end | input | 1 | End-of-timestep marker |
| wmem_rd_en | output | 1 | Weight column read request |
| wmem_rd_col | output | $clog2(COLS) | Column to read |
| wmem_rd_data | input | ROWS*16 | Weight column, one cycle after the request |
| done | output | 1 | Timestep result complete |
| acc_vec | output | ROWS*32 | Raw Q16.16 accumulators |
| res_vec | output | ROWS*16 | Rescaled Q8.8 results |

## Verification
The bench uses the defaults: 8 rows, 8 columns and 4 lanes. Each lane therefore holds two rows, and every column index fits the 3-bit index without any range gaps. With two columns filled with the 16-bit extremes, a few full-scale deltas drive the accumulators past both 32-bit limits. Weights of mixed sign in the other columns exercise truncation of negative values in the Q8.8 readout.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  parameter int DW   = 16;
  parameter int AW   = 32;
  parameter int FRAC = 8;

  function automatic logic signed [AW-1:0] q_mul(input logic signed [DW-1:0] a,
                                                 input logic signed [DW-1:0] b);
    return AW'(a) * AW'(b);
  endfunction

  function automatic logic signed [AW-1:0] sat_add(input logic signed [AW-1:0] a,
                                                   input logic signed [AW-1:0] b);
    logic signed [AW:0] s;
    s = (AW+1)'(a) + (AW+1)'(b);
    if (s[AW] != s[AW-1])
      return s[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
    return s[AW-1:0];
  endfunction

  function automatic logic signed [AW-1:0] q_seed(input logic signed [DW-1:0] b);
    return AW'(b) <<< FRAC;
  endfunction

  function automatic logic [DW-1:0] q_out(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] t;
    t = a >>> FRAC;
    return t[DW-1:0];
  endfunction
endpackage

// File: rtl/dmx_front.sv
module dmx_front
  import dmx_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [IDXW-1:0]      in_idx,
  input  logic signed [DW-1:0] in_delta,
  input  logic                 ts_end,
  output logic                 rd_en,
  output logic [IDXW-1:0]      rd_col,
  output logic                 iss_v,
  output logic signed [DW-1:0] iss_delta,
  output logic                 done
);
  logic end_d1, end_d2;

  assign rd_en  = in_valid && (in_delta != '0);
  assign rd_col = in_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_v     <= 1'b0;
      iss_delta <= '0;
      end_d1    <= 1'b0;
      end_d2    <= 1'b0;
      done      <= 1'b0;
    end else begin
      iss_v     <= rd_en;
      iss_delta <= rd_en ? in_delta : '0;
      end_d1    <= ts_end;
      end_d2    <= end_d1;
      done      <= end_d2;
    end
  end

  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    ts_end |-> ##3 done) else $error("done missing after ts_end"); // R5
endmodule

// File: rtl/dmx_lane.sv
module dmx_lane
  import dmx_pkg::*;
#(
  parameter int RPL = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iss_v,
  input  logic signed [DW-1:0]  iss_delta,
  input  logic [RPL*DW-1:0]     wcol,
  input  logic                  bias_load,
  input  logic                  bias_use,
  input  logic [RPL*DW-1:0]     bias,
  output logic [RPL*AW-1:0]     acc_o
);
  logic                 prod_v;
  logic signed [AW-1:0] prod [RPL];
  logic signed [AW-1:0] acc  [RPL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_v <= 1'b0;
      for (int i = 0; i < RPL; i++) prod[i] <= '0;
    end else begin
      prod_v <= iss_v;
      for (int i = 0; i < RPL; i++) prod[i] <= q_mul(iss_delta, wcol[i*DW +: DW]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RPL; i++) acc[i] <= '0;
    end else if (bias_load) begin
      for (int i = 0; i < RPL; i++) acc[i] <= bias_use ? q_seed(bias[i*DW +: DW]) : '0;
    end else if (prod_v) begin
      for (int i = 0; i < RPL; i++) acc[i] <= sat_add(acc[i], prod[i]);
    end
  end

  for (genvar g = 0; g < RPL; g++) begin : g_pack
    assign acc_o[g*AW +: AW] = acc[g];
  end

  AST_MAC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    iss_v |-> iss_delta != '0) else $error("zero delta issued"); // R3
  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!prod_v && !bias_load) |=> $stable(acc[0])) else $error("acc moved"); // R3
  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_load && !bias_use) |=> acc[0] == '0) else $error("seed not zero"); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_v && !bias_load && prod[0] >= 0) |=> acc[0] >= $past(acc[0])) else $error("wrap"); // R6
endmodule

// File: rtl/delta_mxv_acc.sv
module delta_mxv_acc
  import dmx_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int LANES = 4,
  parameter int IDXW  = $clog2(COLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bias_load,
  input  logic                 bias_use,
  input  logic [ROWS*DW-1:0]   bias_vec,
  input  logic                 in_valid,
  input  logic [IDXW-1:0]      in_idx,
  input  logic [DW-1:0]        in_delta,
  input  logic                 ts_end,
  output logic                 wmem_rd_en,
  output logic [IDXW-1:0]      wmem_rd_col,
  input  logic [ROWS*DW-1:0]   wmem_rd_data,
  output logic                 done,
  output logic [ROWS*AW-1:0]   acc_vec,
  output logic [ROWS*DW-1:0]   res_vec
);
  localparam int RPL = ROWS / LANES;

  logic                 iss_v;
  logic signed [DW-1:0] iss_delta;

  dmx_front #(.IDXW(IDXW)) u_front (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_idx(in_idx), .in_delta(in_delta), .ts_end(ts_end),
    .rd_en(wmem_rd_en), .rd_col(wmem_rd_col),
    .iss_v(iss_v), .iss_delta(iss_delta), .done(done)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dmx_lane #(.RPL(RPL)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .iss_v(iss_v), .iss_delta(iss_delta),
      .wcol(wmem_rd_data[l*RPL*DW +: RPL*DW]),
      .bias_load(bias_load), .bias_use(bias_use),
      .bias(bias_vec[l*RPL*DW +: RPL*DW]),
      .acc_o(acc_vec[l*RPL*AW +: RPL*AW])
    );
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_res
    assign res_vec[r*DW +: DW] = q_out(acc_vec[r*AW +: AW]);
  end

  AST_READ_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    wmem_rd_en |=> iss_v) else $error("read without issue"); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(ts_end, 2)) |=> !done) else $error("done held"); // R5
endmodule

// File: tb/test_delta_mxv_acc.sv
module test_delta_mxv_acc;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bias_load = 0, bias_use = 0;
  logic [ROWS*16-1:0] bias_vec = '0;
  logic in_valid = 0, ts_end = 0;
  logic [IW-1:0] in_idx = '0;
  logic [15:0] in_delta = '0;
  logic wmem_rd_en, done;
  logic [IW-1:0] wmem_rd_col;
  logic [ROWS*16-1:0] wmem_rd_data = '0;
  logic [ROWS*32-1:0] acc_vec;
  logic [ROWS*16-1:0] res_vec;

  int checks = 0, fails = 0, reads = 0;
  bit finished = 0;
  longint ref_acc [ROWS];
  bit s1_v, s2_v, m_e1, m_e2, ref_done;
  int s1_i, s2_i;
  longint s1_d, s2_d;
  string phase = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  delta_mxv_acc i_delta_mxv_acc (.*);

  function automatic int wgt(int c, int r);
    if (c == 7) return 32767;
    if (c == 6) return -32768;
    return ((c*37 + r*11 + 5) % 200 - 100) * 13;
  endfunction

  function automatic longint clamp(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  always @(posedge clk) begin
    if (wmem_rd_en) reads++;
    for (int r = 0; r < ROWS; r++) wmem_rd_data[r*16 +: 16] <= 16'(wgt(int'(wmem_rd_col), r));
  end

  // behavioural reference: two-stage delay line, then fold into running sums
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) ref_acc[r] = 0;
      s1_v = 0; s2_v = 0; m_e1 = 0; m_e2 = 0; ref_done = 0;
    end else begin
      if (s2_v)
        for (int r = 0; r < ROWS; r++) ref_acc[r] = clamp(ref_acc[r] + longint'(wgt(s2_i, r)) * s2_d);
      if (bias_load)
        for (int r = 0; r < ROWS; r++)
          ref_acc[r] = bias_use ? longint'($signed(bias_vec[r*16 +: 16])) * 256 : 0;
      s2_v = s1_v; s2_i = s1_i; s2_d = s1_d;
      s1_v = in_valid; s1_i = int'(in_idx); s1_d = longint'($signed(in_delta));
      ref_done = m_e2; m_e2 = m_e1; m_e1 = ts_end;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_state();
    for (int r = 0; r < ROWS; r++) begin
      chk(phase, longint'($signed(acc_vec[r*32 +: 32])), ref_acc[r]);
      chk("R7", longint'(res_vec[r*16 +: 16]), (ref_acc[r] >>> 8) & 64'hFFFF);
    end
    chk("R5", longint'(done), longint'(ref_done));
  endtask

  task automatic cyc(bit v, int idx, int d, bit e);
    @(negedge clk);
    compare_state();
    in_valid = v; in_idx = IW'(idx); in_delta = 16'(d); ts_end = e;
    #1;
    chk(d != 0 && v ? "R1" : "R3", longint'(wmem_rd_en), longint'(v && d != 0));
    if (v && d != 0) chk("R1", longint'(wmem_rd_col), longint'(idx));
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0);
  endtask

  task automatic seed(bit use_b);
    @(negedge clk);
    compare_state();
    in_valid = 0; ts_end = 0;
    for (int r = 0; r < ROWS; r++) bias_vec[r*16 +: 16] = 16'(r*100 - 300);
    bias_use = use_b; bias_load = 1;
    @(negedge clk);
    bias_load = 0;
    for (int r = 0; r < ROWS; r++)
      chk("R4", longint'($signed(acc_vec[r*32 +: 32])), use_b ? longint'((r*100 - 300) * 256) : 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int rd0;
    repeat (3) @(negedge clk);
    // R8 reset state
    for (int r = 0; r < ROWS; r++) chk("R8", longint'(acc_vec[r*32 +: 32]), 0);
    chk("R8", longint'(done), 0);
    chk("R8", longint'(wmem_rd_en), 0);
    rst_n = 1;
    seed(1);
    // R2 dense timestep with mixed signs
    phase = "R2";
    for (int c = 0; c < 6; c++) cyc(1, c, (c % 2) ? -(c*40 + 3) : (c*25 + 7), c == 5);
    idle(4);
    // R2 sparse timestep, repeated index, end marker alone
    cyc(1, 3, 1000, 0); cyc(0, 0, 0, 0); cyc(1, 3, -250, 0); cyc(1, 1, 77, 0);
    cyc(0, 0, 0, 1);
    idle(4);
    // R3 zero deltas: no reads, no change
    phase = "R3";
    rd0 = reads;
    for (int c = 0; c < COLS; c++) cyc(1, c, 0, c == COLS-1);
    idle(4);
    chk("R3", longint'(reads - rd0), 0);
    // R1 back-to-back reads counted
    phase = "R1";
    rd0 = reads;
    for (int c = 0; c < 6; c++) cyc(1, 5 - c, 11 * (c + 1), 0);
    cyc(0, 0, 0, 1);
    idle(4);
    chk("R1", longint'(reads - rd0), 6);
    // R4 zero seed, then R6 saturation both ways
    seed(0);
    phase = "R6";
    for (int k = 0; k < 4; k++) cyc(1, 7, 32767, k == 3);
    idle(4);
    chk("R6", longint'($signed(acc_vec[31:0])), 64'sd2147483647);
    for (int k = 0; k < 6; k++) cyc(1, 6, 32767, k == 5);
    idle(4);
    chk("R6", longint'($signed(acc_vec[31:0])), -64'sd2147483648);
    for (int k = 0; k < 2; k++) cyc(1, 6, 32767, k == 1);
    idle(4);
    chk("R6", longint'($signed(acc_vec[31:0])), -64'sd2147483648);
    idle(2);
    summary();
  end
endmodule